// File: doc/BRIEF.md
# Programmable Inertial Interrupt Generator

This block watches a stream of signed three-axis acceleration samples and raises an interrupt when the samples meet a programmed rule. Each axis gives a "high" and a "low" event by comparing the magnitude of its sample with an unsigned threshold. Only the upper bits of the magnitude take part, so the threshold spans the whole sample range. The events are combined under one of four rules, selected by two configuration bits:

- an OR of the enabled events;
- an AND of the enabled events;
- a six-direction position rule: exactly one enabled direction is active;
- a six-direction movement rule: the set of active directions changed since the previous sample.

The combined condition must hold for a programmed number of consecutive samples before it counts. The result appears in an interrupt-active flag and in six event bits of a source byte. The result can either follow each new sample or be held until software reads the source byte. The interrupt pin takes a selectable polarity and can be driven push-pull or open-drain.

Sample filtering and the register interface sit outside this block. The block sees samples with a valid strobe, the configuration values as plain inputs, and a single-cycle read strobe for the source byte.

Top module: `motion_irq_gen`

## Requirements
- R1: After reset the source byte is 0x00. With polarity 0 and push-pull drive, the pin is 0 and is driven.
- R2: The comparison magnitude is |sample| shifted right by 8 (16-bit samples, 7-bit threshold). In OR and AND modes, a high event means magnitude > threshold and a low event means magnitude < threshold; equality gives neither event. The six event bits of the source byte show every axis, whether or not it is enabled. The source byte layout is bit 7 = 0, bit 6 = interrupt active, then bits 5..0 = ZH, ZL, YH, YL, XH, XL. The configuration byte uses the same order for the enables in bits 5..0, with bit 7 = AND/six-direction family select and bit 6 = six-direction select.
- R3: Mode {bit7,bit6} = 00 asserts the condition when any enabled event is set.
- R4: Mode 10 asserts the condition when all enabled events are set. With no event enabled, the condition never asserts.
- R5: Mode 11 (position) asserts the condition when exactly one enabled direction is active. In both six-direction modes, a direction is active when the magnitude exceeds the threshold: H for a non-negative sample, L for a negative sample.
- R6: Mode 01 (movement) asserts the condition when the masked direction set is non-zero and differs from the set of the previous sample.
- R7: The interrupt-active flag sets only on a sample that completes a run of more than the duration value of consecutive condition-true samples. Duration 0 acts on the first such sample.
- R8: With latching off, the interrupt-active flag and the event bits follow each sample, and they change only on samples. A read strobe has no effect.
- R9: With latching on, a set flag and its event bits hold through later samples until a read strobe. The read strobe clears the flag, and the next sample refreshes the event bits.
- R10: The pin level is the flag XOR polarity. In push-pull mode the pin is always driven. In open-drain mode the pin is driven only while its level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | New sample present on the axis inputs |
| x_i | input | 16 | X sample, two's complement |
| y_i | input | 16 | Y sample, two's complement |
| z_i | input | 16 | Z sample, two's complement |
| cfg_i | input | 8 | Mode select and six per-direction enables |
| thr_i | input | 7 | Unsigned threshold |
| dur_i | input | 7 | Minimum run length in samples |
| latch_en_i | input | 1 | Hold the result until a source read |
| src_rd_i | input | 1 | Source byte read strobe |
| pol_i | input | 1 | 0 selects an active-high pin, 1 an active-low pin |
| od_i | input | 1 | 0 selects push-pull, 1 selects open-drain |
| src_o | output | 8 | Source byte |
| irq_pin_o | output | 1 | Interrupt pin level |
| irq_drive_o | output | 1 | Pin output enable |

## Verification
The assertions assume that the duration value does not change between the sample that ends a qualifying run and the sample before it. They also assume that a read strobe lasts exactly one cycle. The bench changes configuration, threshold and duration only after reset and before the first sample of each scenario. It pulses the read strobe for one cycle at a time, and never in the same cycle as a sample.

// File: rtl/motion_irq_pkg.sv
package motion_irq_pkg;

    parameter int unsigned SMP_W = 16;
    parameter int unsigned THR_W = 7;
    parameter int unsigned DUR_W = 7;
    parameter int unsigned N_AXES = 3;

    localparam int unsigned SHIFT = SMP_W - 1 - THR_W;
    localparam int unsigned MAG_W = SMP_W - SHIFT;
    localparam int unsigned RUN_W = DUR_W + 1;

    typedef enum logic [1:0] {
        MODE_OR   = 2'b00,
        MODE_MOVE = 2'b01,
        MODE_AND  = 2'b10,
        MODE_POS  = 2'b11
    } mode_e;

    typedef struct packed {
        logic zh;
        logic zl;
        logic yh;
        logic yl;
        logic xh;
        logic xl;
    } dir_t;

    typedef struct packed {
        mode_e mode;
        dir_t  en;
    } cfg_t;

    function automatic logic [MAG_W-1:0] mag_hi(input logic signed [SMP_W-1:0] s);
        logic [SMP_W-1:0] m;
        m = s[SMP_W-1] ? SMP_W'(-s) : SMP_W'(s);
        return MAG_W'(m >> SHIFT);
    endfunction

endpackage

// File: rtl/motion_axis_cmp.sv
module motion_axis_cmp
    import motion_irq_pkg::*;
(
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic [THR_W-1:0]        thr_i,
    input  logic                    six_d_i,
    output logic                    hi_o,
    output logic                    lo_o
);
    logic [MAG_W-1:0] mag;
    logic             above;
    logic             below;

    always_comb begin
        mag   = mag_hi(smp_i);
        above = mag > MAG_W'(thr_i);
        below = mag < MAG_W'(thr_i);
        if (six_d_i) begin
            hi_o = above & ~smp_i[SMP_W-1];
            lo_o = above &  smp_i[SMP_W-1];
        end else begin
            hi_o = above;
            lo_o = below;
        end
    end
endmodule

// File: rtl/motion_combine.sv
module motion_combine
    import motion_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_i,
    input  cfg_t  cfg_i,
    input  dir_t  ev_i,
    output logic  cond_o
);
    dir_t masked;
    dir_t prev_q;

    always_comb begin
        masked = ev_i & cfg_i.en;
        unique case (cfg_i.mode)
            MODE_OR:   cond_o = |masked;
            MODE_AND:  cond_o = (cfg_i.en != '0) && (masked == cfg_i.en);
            MODE_POS:  cond_o = ($countones(masked) == 1);
            MODE_MOVE: cond_o = (masked != '0) && (masked != prev_q);
            default:   cond_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        prev_q <= '0;
        else if (vld_i) prev_q <= masked;
    end

    // R6: the previous direction set is only replaced on a sample
    a_r6_prev_hold: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(prev_q));
endmodule

// File: rtl/motion_qualify.sv
module motion_qualify
    import motion_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic             cond_i,
    input  dir_t             ev_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic             latch_en_i,
    input  logic             rd_i,
    output logic             ia_o,
    output dir_t             src_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_q, run_nx;
    logic             qual, held, ia_q;
    dir_t             src_q;

    always_comb begin
        if (!cond_i)               run_nx = '0;
        else if (run_q == RUN_MAX) run_nx = run_q;
        else                       run_nx = run_q + 1'b1;
        qual = cond_i && (run_nx > RUN_W'(dur_i));
        held = latch_en_i && ia_q && !rd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            ia_q  <= 1'b0;
            src_q <= '0;
        end else begin
            if (vld_i) run_q <= run_nx;
            if (vld_i && !held) begin
                ia_q  <= qual;
                src_q <= ev_i;
            end else if (rd_i && latch_en_i) begin
                ia_q  <= 1'b0;
            end
        end
    end

    assign ia_o  = ia_q;
    assign src_o = src_q;

    a_r7_run_clear: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !cond_i) |=> (run_q == '0));
    a_r7_min_run: assert property (@(posedge clk) disable iff (rst)
        $rose(ia_q) |-> (run_q > RUN_W'($past(dur_i))));
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!vld_i && !(latch_en_i && rd_i)) |=> ($stable(ia_q) && $stable(src_q)));
    a_r9_latched_hold: assert property (@(posedge clk) disable iff (rst)
        (latch_en_i && ia_q && !rd_i) |=> (ia_q && $stable(src_q)));
    a_r9_read_clear: assert property (@(posedge clk) disable iff (rst)
        (latch_en_i && rd_i && !vld_i) |=> !ia_q);
endmodule

// File: rtl/motion_irq_gen.sv
module motion_irq_gen
    import motion_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld_i,
    input  logic signed [SMP_W-1:0] x_i,
    input  logic signed [SMP_W-1:0] y_i,
    input  logic signed [SMP_W-1:0] z_i,
    input  logic [7:0]              cfg_i,
    input  logic [THR_W-1:0]        thr_i,
    input  logic [DUR_W-1:0]        dur_i,
    input  logic                    latch_en_i,
    input  logic                    src_rd_i,
    input  logic                    pol_i,
    input  logic                    od_i,
    output logic [7:0]              src_o,
    output logic                    irq_pin_o,
    output logic                    irq_drive_o
);
    cfg_t                    cfg;
    logic signed [SMP_W-1:0] smp [N_AXES];
    logic [N_AXES-1:0]       hi, lo;
    dir_t                    ev, src_bits;
    logic                    cond, ia, level;

    assign cfg    = cfg_t'(cfg_i);
    assign smp[0] = x_i;
    assign smp[1] = y_i;
    assign smp[2] = z_i;

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        motion_axis_cmp u_cmp (
            .smp_i   (smp[g]),
            .thr_i   (thr_i),
            .six_d_i (cfg.mode[0]),
            .hi_o    (hi[g]),
            .lo_o    (lo[g])
        );
    end

    assign ev = '{zh: hi[2], zl: lo[2], yh: hi[1], yl: lo[1], xh: hi[0], xl: lo[0]};

    motion_combine u_comb (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (smp_vld_i),
        .cfg_i  (cfg),
        .ev_i   (ev),
        .cond_o (cond)
    );

    motion_qualify u_qual (
        .clk        (clk),
        .rst        (rst),
        .vld_i      (smp_vld_i),
        .cond_i     (cond),
        .ev_i       (ev),
        .dur_i      (dur_i),
        .latch_en_i (latch_en_i),
        .rd_i       (src_rd_i),
        .ia_o       (ia),
        .src_o      (src_bits)
    );

    assign src_o       = {1'b0, ia, src_bits};
    assign level       = ia ^ pol_i;
    assign irq_pin_o   = level;
    assign irq_drive_o = !od_i || !level;

    // R10: an active flag on a push-pull pin shows the active level, driven
    a_r10_pushpull_active: assert property (@(posedge clk) disable iff (rst)
        (!od_i && src_o[6]) |-> (irq_drive_o && (irq_pin_o == !pol_i)));
    // R10: an open-drain pin is released whenever its level is high
    a_r10_od_release: assert property (@(posedge clk) disable iff (rst)
        (od_i && irq_pin_o) |-> !irq_drive_o);
endmodule

// File: tb/motion_irq_gen_tb.sv
module motion_irq_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_vld_i;
    logic signed [15:0] x_i, y_i, z_i;
    logic [7:0]  cfg_i;
    logic [6:0]  thr_i, dur_i;
    logic        latch_en_i, src_rd_i, pol_i, od_i;
    logic [7:0]  src_o;
    logic        irq_pin_o, irq_drive_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    motion_irq_gen dut_i (
        .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i),
        .x_i(x_i), .y_i(y_i), .z_i(z_i),
        .cfg_i(cfg_i), .thr_i(thr_i), .dur_i(dur_i),
        .latch_en_i(latch_en_i), .src_rd_i(src_rd_i),
        .pol_i(pol_i), .od_i(od_i),
        .src_o(src_o), .irq_pin_o(irq_pin_o), .irq_drive_o(irq_drive_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [7:0] cfg, input logic [6:0] dur, input logic latch);
        @(negedge clk);
        rst = 1'b1; smp_vld_i = 1'b0; src_rd_i = 1'b0;
        x_i = '0; y_i = '0; z_i = '0;
        cfg_i = cfg; thr_i = 7'd16; dur_i = dur; latch_en_i = latch;
        pol_i = 1'b0; od_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic smp(input int x, input int y, input int z);
        @(negedge clk);
        x_i = 16'(x); y_i = 16'(y); z_i = 16'(z); smp_vld_i = 1'b1;
        @(negedge clk);
        smp_vld_i = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        src_rd_i = 1'b1;
        @(negedge clk);
        src_rd_i = 1'b0;
    endtask

    task automatic t_reset();
        setup(8'h02, 7'd0, 1'b0);
        chk("R1 source after reset", src_o, 8'h00);
        chk("R1 pin after reset", {6'd0, irq_pin_o, irq_drive_o}, 8'h01);
    endtask

    task automatic t_or();
        setup(8'h02, 7'd0, 1'b0);
        smp(5000, 0, 0);
        chk("R3 OR high X", src_o, 8'h56);
        smp(1000, 0, 0);
        chk("R8 follows drop", src_o, 8'h15);
        smp(-32768, 0, 0);
        chk("R2 most negative sample is high", src_o, 8'h56);
        setup(8'h03, 7'd0, 1'b0);
        smp(4200, 0, 0);
        chk("R2 equal to threshold gives no event", src_o, 8'h14);
    endtask

    task automatic t_and();
        setup(8'h85, 7'd0, 1'b0);
        smp(1000, 1000, 5000);
        chk("R4 AND all enabled set", src_o, 8'h65);
        smp(1000, 5000, 5000);
        chk("R4 AND one missing", src_o, 8'h29);
        setup(8'h80, 7'd0, 1'b0);
        smp(1000, 1000, 1000);
        chk("R4 AND with no enables", src_o, 8'h15);
    endtask

    task automatic t_duration();
        setup(8'h02, 7'd2, 1'b0);
        smp(5000, 0, 0);
        chk("R7 run 1 of 3", src_o, 8'h16);
        smp(5000, 0, 0);
        chk("R7 run 2 of 3", src_o, 8'h16);
        smp(5000, 0, 0);
        chk("R7 run 3 qualifies", src_o, 8'h56);
        smp(1000, 0, 0);
        chk("R7 run broken", src_o, 8'h15);
    endtask

    task automatic t_latch();
        setup(8'h02, 7'd0, 1'b1);
        smp(5000, 0, 0);
        chk("R9 latched set", src_o, 8'h56);
        smp(1000, 0, 0);
        chk("R9 held through sample", src_o, 8'h56);
        rd_pulse();
        chk("R9 read clears flag", src_o, 8'h16);
        smp(1000, 0, 0);
        chk("R9 refresh after read", src_o, 8'h15);
        setup(8'h02, 7'd0, 1'b0);
        smp(5000, 0, 0);
        rd_pulse();
        chk("R8 read ignored when not latched", src_o, 8'h56);
    endtask

    task automatic t_sixd();
        setup(8'hFF, 7'd0, 1'b0);
        smp(5000, 0, 0);
        chk("R5 position single direction", src_o, 8'h42);
        smp(5000, -5000, 0);
        chk("R5 position two directions", src_o, 8'h06);
        setup(8'h7F, 7'd0, 1'b0);
        smp(5000, 0, 0);
        chk("R6 movement first change", src_o, 8'h42);
        smp(5000, 0, 0);
        chk("R6 movement unchanged", src_o, 8'h02);
        smp(-5000, 0, 0);
        chk("R6 movement flip", src_o, 8'h41);
    endtask

    task automatic t_pin();
        setup(8'h02, 7'd0, 1'b0);
        smp(5000, 0, 0);
        chk("R10 high pushpull", {6'd0, irq_pin_o, irq_drive_o}, 8'h03);
        pol_i = 1'b1; #1;
        chk("R10 low pushpull", {6'd0, irq_pin_o, irq_drive_o}, 8'h01);
        od_i = 1'b1; #1;
        chk("R10 low opendrain active", {6'd0, irq_pin_o, irq_drive_o}, 8'h01);
        pol_i = 1'b0; #1;
        chk("R10 high opendrain active", {6'd0, irq_pin_o, irq_drive_o}, 8'h02);
        smp(1000, 0, 0);
        pol_i = 1'b1; #1;
        chk("R10 low opendrain idle", {6'd0, irq_pin_o, irq_drive_o}, 8'h02);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; smp_vld_i = 1'b0; src_rd_i = 1'b0;
        x_i = '0; y_i = '0; z_i = '0; cfg_i = '0; thr_i = '0; dur_i = '0;
        latch_en_i = 1'b0; pol_i = 1'b0; od_i = 1'b0;
        t_reset();
        t_or();
        t_and();
        t_duration();
        t_latch();
        t_sixd();
        t_pin();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule